// File: doc/BRIEF.md
# Fracturable Dual-Output Lookup Table Cell

This block is one programmable logic cell of a soft FPGA fabric model. A 64-bit truth-table word sits in a configuration store. It is written either one bit per clock through a serial input or as a whole word through a parallel input. Six logic inputs steer a binary selection tree over that word. The root of the tree gives a general function of all six inputs. A node one level below the root gives a second function of the lower five inputs, and that second result passes through one more selection stage on its way out.

When the cell is split into two functions, the top input is forced high inside the cell. The main output then reads the upper half of the table and the secondary output reads the lower half, both indexed by the five remaining inputs. A single flip-flop with synchronous reset and clock enable can capture either function. A bypass control decides whether the captured value replaces the combinational value on the output whose function feeds it. Because there is only one flip-flop, at most one output can ever be registered.

Top module: `frac_lut_cell`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the whole truth-table word and the flip-flop, so every output reads 0 after the reset edge.
- R2: While `cfg_en` is high, each rising edge shifts the table word one place toward bit 63 and loads `cfg_ser` into bit 0. After 64 such edges, the first bit sent sits in bit 63 (most significant bit first).
- R3: With `cfg_en` low and `cfg_par_load` high, a rising edge copies `cfg_par_word` into the table. `cfg_en` wins when both are high. With both low, the table keeps its value.
- R4: With `dual_mode` low, `out_main` equals table bit T[idx], where idx = `lut_in` and `lut_in[0]` is the least significant index bit.
- R5: With `dual_mode` high, `lut_in[5]` has no effect and `out_main` equals T[32 + `lut_in[4:0]`], the upper-half five-input function.
- R6: In both modes, `out_sec` equals T[`lut_in[4:0]`], the lower-half node of the selection tree.
- R7: At a rising edge with `ff_ce` high, the flip-flop captures the main function when `ff_src_sel` = 0 and the secondary function when `ff_src_sel` = 1, each evaluated from the inputs and table before that edge. With `ff_ce` low, the flip-flop holds its value.
- R8: With `ff_out_reg` high, the output picked by `ff_src_sel` (0 = `out_main`, 1 = `out_sec`) shows the flip-flop and the other output stays combinational. With `ff_out_reg` low, both outputs are combinational.
- R9: The reset clears the flip-flop even when `ff_ce` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Serial shift enable for the table word |
| cfg_ser | input | 1 | Serial table bit, most significant bit first |
| cfg_par_load | input | 1 | Parallel load strobe |
| cfg_par_word | input | 64 | Parallel table word |
| lut_in | input | 6 | Logic inputs; bit 5 is the top selection input |
| dual_mode | input | 1 | 1 = two five-input functions, 0 = one six-input function |
| ff_ce | input | 1 | Flip-flop clock enable |
| ff_src_sel | input | 1 | Flip-flop source: 0 = main function, 1 = secondary |
| ff_out_reg | input | 1 | 1 = selected output shows the flip-flop |
| out_main | output | 1 | Main output (tree root or flip-flop) |
| out_sec | output | 1 | Secondary output (internal node or flip-flop) |

## Verification
The bench sweeps all 64 indices of a serially loaded asymmetric word. A reversed shift order or a swapped index bit order would show up as mismatches at once. In split mode it toggles the top input across a five-input sweep; a cell that fails to force it high would read the lower half on the main output. It checks that the serial enable wins over a simultaneous parallel load, since the wrong priority would leave an all-ones word in the table. It also checks that the flip-flop captures the function from before the edge, follows the source select, holds when the enable is low, and clears on reset with the enable low; a mix-up of source or routing would put the registered value on the wrong output.

// File: rtl/flut_pkg.sv
package flut_pkg;

    localparam int unsigned LUT_K     = 6;
    localparam int unsigned LUT_SIZE  = 1 << LUT_K;
    localparam int unsigned NODE_CNT  = 2 * LUT_SIZE - 1;

    typedef logic [LUT_SIZE-1:0] lut_word_t;
    typedef logic [LUT_K-1:0]    lut_idx_t;

    typedef enum logic {
        FN_MAIN = 1'b0,
        FN_SEC  = 1'b1
    } fn_sel_e;

    typedef struct packed {
        logic main_fn;
        logic sec_fn;
    } lut_fn_t;

    // In split mode the top selection input is forced to 1.
    function automatic lut_idx_t eff_index(input lut_idx_t raw, input logic dual);
        lut_idx_t r;
        r = raw;
        if (dual) r[LUT_K-1] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/flut_cfg_store.sv
module flut_cfg_store
    import flut_pkg::*;
#(
    parameter int unsigned WIDTH = LUT_SIZE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en_i,
    input  logic             ser_i,
    input  logic             par_load_i,
    input  logic [WIDTH-1:0] par_word_i,
    output logic [WIDTH-1:0] word_o
);

    logic [WIDTH-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (shift_en_i) begin
            word_q <= {word_q[WIDTH-2:0], ser_i};
        end else if (par_load_i) begin
            word_q <= par_word_i;
        end
    end

    assign word_o = word_q;

    // R2: serial shift moves the word up and inserts the new bit at the bottom
    a_r2_shift_msb_first: assert property (@(posedge clk) disable iff (rst)
        shift_en_i |=> (word_q == {$past(word_q[WIDTH-2:0]), $past(ser_i)}));

    // R3: parallel load when serial is idle
    a_r3_par_load: assert property (@(posedge clk) disable iff (rst)
        (!shift_en_i && par_load_i) |=> (word_q == $past(par_word_i)));

    // R3: idle store holds its word
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!shift_en_i && !par_load_i) |=> $stable(word_q));

endmodule

// File: rtl/flut_sel_tree.sv
module flut_sel_tree #(
    parameter int unsigned K = 6
) (
    input  logic [(1<<K)-1:0] table_i,
    input  logic [K-1:0]      sel_i,
    output logic              root_o,
    output logic              node_lo_o
);

    localparam int unsigned N      = 1 << K;
    localparam int unsigned NODES  = 2 * N - 1;

    // Heap layout: node i has children 2i+1 (select 0) and 2i+2 (select 1);
    // leaves occupy indices N-1 .. 2N-2 in table order.
    logic [NODES-1:0] node;

    assign node[NODES-1:N-1] = table_i;

    for (genvar d = 0; d < K; d++) begin : g_depth
        for (genvar m = 0; m < (1 << d); m++) begin : g_node
            localparam int unsigned IDX = (1 << d) - 1 + m;
            assign node[IDX] = sel_i[K-1-d] ? node[2*IDX+2] : node[2*IDX+1];
        end
    end

    assign root_o    = node[0];
    assign node_lo_o = node[1];

endmodule

// File: rtl/flut_out_stage.sv
module flut_out_stage
    import flut_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  lut_fn_t fn_i,
    input  logic    ce_i,
    input  fn_sel_e src_i,
    input  logic    out_reg_i,
    output logic    out_main_o,
    output logic    out_sec_o
);

    logic q;
    logic d_src;
    logic sec_stage;

    assign d_src = (src_i == FN_SEC) ? fn_i.sec_fn : fn_i.main_fn;

    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (ce_i) q <= d_src;
    end

    // Main path leaves directly unless it owns the register.
    assign out_main_o = (out_reg_i && src_i == FN_MAIN) ? q : fn_i.main_fn;

    // Secondary path passes through an extra selection stage.
    always_comb begin
        sec_stage = fn_i.sec_fn;
        if (out_reg_i && src_i == FN_SEC) sec_stage = q;
    end
    assign out_sec_o = sec_stage;

    // R9: reset clears the register regardless of enable
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (q == 1'b0));

    // R7: enabled capture takes the selected function from before the edge
    a_r7_capture: assert property (@(posedge clk) disable iff (rst)
        ce_i |=> (q == ($past(src_i) == FN_SEC ? $past(fn_i.sec_fn) : $past(fn_i.main_fn))));

    // R7: disabled register holds
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !ce_i |=> $stable(q));

endmodule

// File: rtl/frac_lut_cell.sv
module frac_lut_cell
    import flut_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_en,
    input  logic                cfg_ser,
    input  logic                cfg_par_load,
    input  logic [LUT_SIZE-1:0] cfg_par_word,
    input  logic [LUT_K-1:0]    lut_in,
    input  logic                dual_mode,
    input  logic                ff_ce,
    input  logic                ff_src_sel,
    input  logic                ff_out_reg,
    output logic                out_main,
    output logic                out_sec
);

    lut_word_t cfg_word;
    lut_idx_t  sel;
    lut_fn_t   fn;
    fn_sel_e   src;

    flut_cfg_store #(.WIDTH(LUT_SIZE)) u_store (
        .clk        (clk),
        .rst        (rst),
        .shift_en_i (cfg_en),
        .ser_i      (cfg_ser),
        .par_load_i (cfg_par_load),
        .par_word_i (cfg_par_word),
        .word_o     (cfg_word)
    );

    assign sel = eff_index(lut_in, dual_mode);

    flut_sel_tree #(.K(LUT_K)) u_tree (
        .table_i   (cfg_word),
        .sel_i     (sel),
        .root_o    (fn.main_fn),
        .node_lo_o (fn.sec_fn)
    );

    assign src = fn_sel_e'(ff_src_sel);

    flut_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .fn_i       (fn),
        .ce_i       (ff_ce),
        .src_i      (src),
        .out_reg_i  (ff_out_reg),
        .out_main_o (out_main),
        .out_sec_o  (out_sec)
    );

    // R6: combinational secondary output reads the lower half of the table
    a_r6_sec_lower_half: assert property (@(posedge clk) disable iff (rst)
        !(ff_out_reg && ff_src_sel) |-> (out_sec == cfg_word[{1'b0, lut_in[LUT_K-2:0]}]));

    // R5: split mode main output reads the upper half, top input ignored
    a_r5_dual_upper_half: assert property (@(posedge clk) disable iff (rst)
        (dual_mode && !(ff_out_reg && !ff_src_sel)) |-> (out_main == cfg_word[{1'b1, lut_in[LUT_K-2:0]}]));

    // R4: single mode main output reads the full six-input index
    a_r4_single_full: assert property (@(posedge clk) disable iff (rst)
        (!dual_mode && !(ff_out_reg && !ff_src_sel)) |-> (out_main == cfg_word[lut_in]));

endmodule

// File: tb/frac_lut_cell_tb_top.sv
module frac_lut_cell_tb_top;
    import flut_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic        cfg_en = 1'b0;
    logic        cfg_ser = 1'b0;
    logic        cfg_par_load = 1'b0;
    logic [63:0] cfg_par_word = '0;
    logic [5:0]  lut_in = '0;
    logic        dual_mode = 1'b0;
    logic        ff_ce = 1'b0;
    logic        ff_src_sel = 1'b0;
    logic        ff_out_reg = 1'b0;
    logic        out_main;
    logic        out_sec;

    frac_lut_cell dut_i (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_ser(cfg_ser),
        .cfg_par_load(cfg_par_load), .cfg_par_word(cfg_par_word),
        .lut_in(lut_in), .dual_mode(dual_mode), .ff_ce(ff_ce),
        .ff_src_sel(ff_src_sel), .ff_out_reg(ff_out_reg),
        .out_main(out_main), .out_sec(out_sec)
    );

    typedef struct {
        logic  m;
        logic  s;
        string tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    logic [63:0] mt = '0;
    logic        mq = 1'b0;
    bit          done = 1'b0;

    localparam logic [63:0] KSER = 64'hF0E1_D2C3_B4A5_9687;
    localparam logic [63:0] KPAR = 64'h3C5A_0FF1_9E27_C6B4;

    function automatic logic f_main(logic [63:0] t, logic [5:0] i, logic d);
        return d ? t[{1'b1, i[4:0]}] : t[i];
    endfunction

    function automatic logic f_sec(logic [63:0] t, logic [5:0] i);
        return t[{1'b0, i[4:0]}];
    endfunction

    // Driver: apply one cycle of stimulus, advance the model, push expectation.
    task automatic step(input logic r, input logic en, input logic ser,
                        input logic pl, input logic [63:0] pw,
                        input logic [5:0] li, input logic dm,
                        input logic ce, input logic src, input logic oreg,
                        input string tag);
        logic nq;
        @(negedge clk);
        rst = r; cfg_en = en; cfg_ser = ser; cfg_par_load = pl;
        cfg_par_word = pw; lut_in = li; dual_mode = dm;
        ff_ce = ce; ff_src_sel = src; ff_out_reg = oreg;
        if (r) begin
            mt = '0;
            mq = 1'b0;
        end else begin
            nq = ce ? (src ? f_sec(mt, li) : f_main(mt, li, dm)) : mq;
            if (en)      mt = {mt[62:0], ser};
            else if (pl) mt = pw;
            mq = nq;
        end
        sb.push_back('{(oreg && !src) ? mq : f_main(mt, li, dm),
                       (oreg && src)  ? mq : f_sec(mt, li),
                       tag});
    endtask

    // Monitor: compare after each edge, away from it.
    initial begin
        exp_t it;
        forever begin
            @(posedge clk);
            #3;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                checks++;
                if (out_main !== it.m || out_sec !== it.s) begin
                    errors++;
                    $display("FAIL %s: main=%b sec=%b expected main=%b sec=%b",
                             it.tag, out_main, out_sec, it.m, it.s);
                end
            end
        end
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, register enabled and routed to main
        for (int k = 0; k < 3; k++)
            step(1, 0, 0, 0, '0, 6'(k * 21), 0, 1, 0, 1, "R1 reset");

        // R2: serial load, most significant bit first
        for (int b = 63; b >= 0; b--)
            step(0, 1, KSER[b], 0, '0, 6'(b), 0, 0, 0, 0, "R2 serial");

        // R4: full six-input sweep of the serially loaded word
        for (int i = 0; i < 64; i++)
            step(0, 0, 0, 0, '0, 6'(i), 0, 0, 0, 0, "R4 single");

        // R3: parallel load, priority of serial, hold when idle
        step(0, 0, 0, 1, KPAR, 6'd5, 0, 0, 0, 0, "R3 parallel");
        step(0, 1, 1, 1, '1, 6'd40, 0, 0, 0, 0, "R3 priority");
        step(0, 0, 0, 0, '1, 6'd63, 0, 0, 0, 0, "R3 hold");
        step(0, 0, 0, 0, '0, 6'd0, 0, 0, 0, 0, "R3 hold");

        // R5 R6: split mode, top input toggled
        for (int i = 0; i < 32; i++)
            step(0, 0, 0, 0, '0, {1'(i[0] ^ i[2]), 5'(i)}, 1, 0, 0, 0, "R5 R6 dual");

        // R6: secondary in single mode
        for (int i = 0; i < 64; i += 7)
            step(0, 0, 0, 0, '0, 6'(i), 0, 0, 0, 0, "R6 single sec");

        // R7: capture main function, registered on main
        for (int i = 0; i < 12; i++)
            step(0, 0, 0, 0, '0, 6'(i * 5 + 3), 0, 1, 0, 1, "R7 capture main");
        // R7: hold with enable low while inputs move
        for (int i = 0; i < 6; i++)
            step(0, 0, 0, 0, '0, 6'(i * 11), 0, 0, 0, 1, "R7 hold");

        // R8: register secondary in split mode, main stays combinational
        for (int i = 0; i < 12; i++)
            step(0, 0, 0, 0, '0, 6'(i * 9 + 1), 1, 1, 1, 1, "R8 reg sec");
        // R8: bypass, both combinational while register keeps capturing
        for (int i = 0; i < 8; i++)
            step(0, 0, 0, 0, '0, 6'(i * 13 + 2), i[0], 1, i[1], 0, "R8 bypass");

        // Load a word of ones so the register holds 1 before reset
        step(0, 0, 0, 1, '1, 6'd0, 0, 1, 0, 1, "R3 parallel ones");
        step(0, 0, 0, 0, '0, 6'd7, 0, 1, 0, 1, "R7 capture one");
        // R9: reset with enable low clears register and table
        step(1, 0, 0, 0, '0, 6'd7, 0, 0, 0, 1, "R9 reset ce low");
        step(0, 0, 0, 0, '0, 6'd33, 1, 0, 1, 1, "R9 after reset");
        step(0, 0, 0, 0, '0, 6'd12, 0, 0, 0, 0, "R1 table cleared");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule